// File: doc/BRIEF.md
# I2C Device Identity Read Sequencer

This block sits behind the bit-level engine of an I2C target. It receives decoded bus events (START or repeated START, STOP), the bytes the controller writes, and the controller's acknowledge bit after each byte the target sends. From these it follows the reserved identity transaction, which spans several bus phases. First comes a START with the reserved identity write address F8h. Next comes a byte that names one target's own 7-bit address. Last comes a repeated START with the reserved identity read address F9h. When that sequence names this target, the block asks the bit engine to acknowledge each step. It then presents a hard-wired identity value one byte at a time for transmission.

The identity is a parameter of 8·N bits and is sent most significant byte first. The default is 24'h000800: a 12-bit maker field of zeros, a 9-bit part field of 100000000b, and a 3-bit revision of zero. This gives the bytes 00h, 08h, 00h. While the controller acknowledges, the readout cycles through the bytes without end. A not-acknowledge, a STOP, or any break in the sequence returns the block to idle.

Top module: `i2c_devid_seq`

## Requirements
- R1: After a synchronous reset, `ack_req` is 0, `tx_en` is 0 and `tx_byte` is FFh.
- R2: The first byte after a START or repeated START sets `ack_req` to 1 only if it equals F8h. Any other first byte, 48h included, leaves `ack_req` at 0.
- R3: The byte after an accepted F8h is acknowledged only when its bits 7..1 equal `own_addr`. Bit 0 has no effect on this. A different address gives `ack_req` 0 and ends the sequence.
- R4: After the own-address byte, a repeated START followed by F9h sets `ack_req` to 1 and `tx_en` to 1 in the next cycle, and `tx_byte` then shows identity byte 0.
- R5: F9h received after a START without the armed sequence gives `ack_req` 0 and `tx_en` 0.
- R6: Identity bytes are presented most significant byte first. With the default value, the bytes are 00h, 08h, 00h, and `tx_byte` changes only on a `tx_done` pulse.
- R7: A `tx_done` with `tx_acked` 1 on the last identity byte brings `tx_byte` back to byte 0, and the readout continues.
- R8: A `tx_done` with `tx_acked` 0 during readout clears `tx_en` in the next cycle. A later START followed by F9h is not acknowledged.
- R9: A STOP at any point clears `ack_req` and `tx_en` in the next cycle. If the STOP comes between the own-address byte and the repeated START, a later START followed by F9h is not acknowledged.
- R10: When the block is armed, a repeated START followed by any address other than F9h gives `ack_req` 0 and drops the armed state.
- R11: `ack_req` holds its last decision until the next received byte, START or STOP. A START or STOP clears it to 0.
- R12: Whenever `tx_en` is 0, `tx_byte` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | This target's 7-bit bus address |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on STOP |
| rx_valid | input | 1 | One-cycle pulse: a byte from the controller is complete |
| rx_data | input | 8 | Byte received with `rx_valid` |
| tx_done | input | 1 | One-cycle pulse: controller acknowledge bit for a sent byte |
| tx_acked | input | 1 | 1 if the controller acknowledged, 0 for not-acknowledge |
| ack_req | output | 1 | Request to acknowledge the byte just received |
| tx_en | output | 1 | Identity readout is active |
| tx_byte | output | 8 | Next byte to transmit (FFh when idle) |

## Verification
The assertions check on every cycle the rules that hold locally in time. A STOP always clears both outputs. Readout can only begin right after an F9h byte. A not-acknowledge ends the readout. `ack_req` can only rise after a received byte. `tx_byte` is FFh while idle and stays steady between `tx_done` pulses. Only the bench's scenarios can show the rules that span several transactions: arming through the own address with bit 0 ignored, losing the arm on a STOP or a foreign address, refusing an unarmed F9h, and the exact byte order and wrap of the identity.

// File: rtl/devid_pkg.sv
// Package: shared constants and the state type of the identity read sequencer.
// Assumes 7-bit I2C addressing with the R/W flag in bit 0 of address bytes.
package devid_pkg;
    localparam int          ADDR_W     = 7;
    localparam logic [7:0]  RSV_ID_WR  = 8'hF8;
    localparam logic [7:0]  RSV_ID_RD  = 8'hF9;
    localparam logic [7:0]  IDLE_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,      // nothing in progress
        ST_FIRST,     // START seen, waiting for the first address byte
        ST_GOT_RSV,   // F8h accepted, waiting for the target address byte
        ST_ARMED,     // own address named, waiting for the repeated START
        ST_ARM_RS,    // repeated START while armed, waiting for F9h
        ST_SERVE      // identity readout in progress
    } seq_state_t;
endpackage

// File: rtl/devid_byte_ptr.sv
// Module: wrapping byte index for the identity readout.
// Clears to zero on request and advances by one per acknowledged byte,
// going from NUM_BYTES-1 back to zero. Assumes clear and advance are exclusive.
module devid_byte_ptr #(
    parameter int NUM_BYTES = 3,
    parameter int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BYTES - 1);

    // Index register: clear on readout entry, wrap at the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/devid_byte_mux.sv
// Module: selects one byte of the identity value, most significant byte first.
// Drives FFh (released line) when not enabled. Assumes sel < NUM_BYTES when enabled.
module devid_byte_mux #(
    parameter int                   NUM_BYTES = 3,
    parameter logic [8*NUM_BYTES-1:0] ID_VALUE = 24'h000800,
    parameter int                   PTR_W     = 2
) (
    input  logic             enable,
    input  logic [PTR_W-1:0] sel,
    output logic [7:0]       byte_o
);
    import devid_pkg::*;

    logic [7:0] id_bytes [NUM_BYTES];

    // Slice the identity into bytes, index 0 being the most significant.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
        assign id_bytes[g] = ID_VALUE[8*(NUM_BYTES-1-g) +: 8];
    end

    // Byte selection with an idle default.
    always_comb begin
        byte_o = IDLE_BYTE;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (enable && sel == PTR_W'(i)) byte_o = id_bytes[i];
        end
    end
endmodule

// File: rtl/devid_fsm.sv
// Module: transaction tracker for the reserved identity read.
// Consumes decoded bus events; STOP has priority over START, and START over
// byte and acknowledge events in the same cycle. Produces the acknowledge
// request and the pointer controls for the readout.
module devid_fsm (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [devid_pkg::ADDR_W-1:0] own_addr,
    input  logic                         start_seen,
    input  logic                         stop_seen,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         tx_done,
    input  logic                         tx_acked,
    output devid_pkg::seq_state_t        state,
    output logic                         ack_req,
    output logic                         ptr_clear,
    output logic                         ptr_adv
);
    import devid_pkg::*;

    seq_state_t state_nx;
    logic       ack_nx;
    logic       own_match;

    // Address comparison ignores the R/W bit.
    assign own_match = (rx_data[7:1] == own_addr);

    // Next state and acknowledge decision.
    always_comb begin
        state_nx  = state;
        ack_nx    = ack_req;
        ptr_clear = 1'b0;
        ptr_adv   = 1'b0;
        if (stop_seen) begin
            state_nx = ST_IDLE;
            ack_nx   = 1'b0;
        end else if (start_seen) begin
            state_nx = (state == ST_ARMED) ? ST_ARM_RS : ST_FIRST;
            ack_nx   = 1'b0;
        end else if (rx_valid) begin
            ack_nx   = 1'b0;
            state_nx = ST_IDLE;
            unique case (state)
                ST_FIRST: if (rx_data == RSV_ID_WR) begin
                    state_nx = ST_GOT_RSV;
                    ack_nx   = 1'b1;
                end
                ST_GOT_RSV: if (own_match) begin
                    state_nx = ST_ARMED;
                    ack_nx   = 1'b1;
                end
                ST_ARM_RS: if (rx_data == RSV_ID_RD) begin
                    state_nx  = ST_SERVE;
                    ack_nx    = 1'b1;
                    ptr_clear = 1'b1;
                end
                default: ;
            endcase
        end else if (tx_done && state == ST_SERVE) begin
            if (tx_acked) ptr_adv  = 1'b1;
            else          state_nx = ST_IDLE;
        end
    end

    // State and acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ack_req <= 1'b0;
        end else begin
            state   <= state_nx;
            ack_req <= ack_nx;
        end
    end
endmodule

// File: rtl/i2c_devid_seq.sv
// Module: top of the identity read sequencer.
// Ties the transaction tracker, the wrapping byte index and the identity byte
// selector. Assumes the bit engine delivers one-cycle event pulses.
module i2c_devid_seq #(
    parameter int                     ID_BYTES = 3,
    parameter logic [8*ID_BYTES-1:0]  ID_VALUE = 24'h000800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] own_addr,
    input  logic       start_seen,
    input  logic       stop_seen,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_done,
    input  logic       tx_acked,
    output logic       ack_req,
    output logic       tx_en,
    output logic [7:0] tx_byte
);
    import devid_pkg::*;

    localparam int PTR_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    seq_state_t       state;
    logic             ptr_clear;
    logic             ptr_adv;
    logic [PTR_W-1:0] ptr;

    devid_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_addr   (own_addr),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_done    (tx_done),
        .tx_acked   (tx_acked),
        .state      (state),
        .ack_req    (ack_req),
        .ptr_clear  (ptr_clear),
        .ptr_adv    (ptr_adv)
    );

    devid_byte_ptr #(.NUM_BYTES(ID_BYTES), .PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ptr_clear),
        .advance (ptr_adv),
        .ptr     (ptr)
    );

    // Readout is active only in the serving state.
    assign tx_en = (state == ST_SERVE);

    devid_byte_mux #(.NUM_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE), .PTR_W(PTR_W)) u_mux (
        .enable (tx_en),
        .sel    (ptr),
        .byte_o (tx_byte)
    );
endmodule

// File: rtl/i2c_devid_seq_chk.sv
// Checker: port-level temporal rules of the identity read sequencer.
module i2c_devid_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       tx_done,
    input logic       tx_acked,
    input logic       ack_req,
    input logic       tx_en,
    input logic [7:0] tx_byte
);
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!ack_req && !tx_en));

    assert_serve_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(rx_valid && rx_data == 8'hF9));

    assert_nack_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_done && !tx_acked && !rx_valid) |=> !tx_en);

    assert_idle_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_byte == 8'hFF));

    assert_ack_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(rx_valid));

    assert_byte_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$past(tx_done)) |-> $stable(tx_byte));
endmodule

bind i2c_devid_seq i2c_devid_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .tx_done    (tx_done),
    .tx_acked   (tx_acked),
    .ack_req    (ack_req),
    .tx_en      (tx_en),
    .tx_byte    (tx_byte)
);

// File: tb/tb_i2c_devid_seq.sv
module tb_i2c_devid_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = 7'h24;
    logic       start_seen = 1'b0, stop_seen = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_done = 1'b0, tx_acked = 1'b0;
    logic       ack_req, tx_en;
    logic [7:0] tx_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    i2c_devid_seq dut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_done(tx_done), .tx_acked(tx_acked),
        .ack_req(ack_req), .tx_en(tx_en), .tx_byte(tx_byte)
    );

    // Behavioural reference: phase counter plus a byte queue.
    byte unsigned id_q[$] = '{8'h00, 8'h08, 8'h00};
    int  phase = 0;   // 0 idle,1 after start,2 got F8,3 armed,4 armed+restart,5 reading
    int  idx   = 0;
    bit  m_ack = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; idx = 0; m_ack = 0;
        end else if (stop_seen) begin
            phase = 0; m_ack = 0;
        end else if (start_seen) begin
            phase = (phase == 3) ? 4 : 1; m_ack = 0;
        end else if (rx_valid) begin
            m_ack = 0;
            if (phase == 1 && rx_data == 8'hF8)               begin phase = 2; m_ack = 1; end
            else if (phase == 2 && rx_data[7:1] == own_addr)  begin phase = 3; m_ack = 1; end
            else if (phase == 4 && rx_data == 8'hF9)          begin phase = 5; m_ack = 1; idx = 0; end
            else phase = 0;
        end else if (tx_done && phase == 5) begin
            if (tx_acked) idx = (idx + 1) % id_q.size();
            else phase = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference (R4 R6 R7 R8 R11 R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(ack_req == m_ack, "R11 per-cycle ack_req", ack_req, m_ack);
            check(tx_en == (phase == 5), "R4 per-cycle tx_en", tx_en, phase == 5);
            check(tx_byte == ((phase == 5) ? id_q[idx] : 8'hFF), "R6 per-cycle tx_byte",
                  tx_byte, (phase == 5) ? id_q[idx] : 8'hFF);
        end
    end

    task automatic ev_start();
        @(negedge clk); start_seen = 1'b1; @(negedge clk); start_seen = 1'b0; #1;
    endtask
    task automatic ev_stop();
        @(negedge clk); stop_seen = 1'b1; @(negedge clk); stop_seen = 1'b0; #1;
    endtask
    task automatic ev_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b; @(negedge clk); rx_valid = 1'b0; #1;
    endtask
    task automatic ev_tx(input bit a);
        @(negedge clk); tx_done = 1'b1; tx_acked = a; @(negedge clk); tx_done = 1'b0; #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(ack_req == 0 && tx_en == 0 && tx_byte == 8'hFF, "R1 reset", {ack_req, tx_en, tx_byte}, 10'h0FF);
        rst_n = 1'b1;

        // Full sequence with wrap and NACK.
        ev_start();
        ev_byte(8'h48);  check(ack_req == 0, "R2 non-reserved first byte", ack_req, 0);
        ev_start();
        ev_byte(8'hF8);  check(ack_req == 1, "R2 F8 acked", ack_req, 1);
        ev_byte(8'h49);  check(ack_req == 1, "R3 own addr bit0 ignored", ack_req, 1);
        ev_start();      check(ack_req == 0, "R11 start clears ack", ack_req, 0);
        ev_byte(8'hF9);  check(ack_req == 1 && tx_en == 1, "R4 F9 accepted", {ack_req, tx_en}, 2'b11);
        check(tx_byte == 8'h00, "R6 byte0", tx_byte, 8'h00);
        repeat (3) @(negedge clk);
        check(tx_byte == 8'h00 && ack_req == 1, "R11 hold without events", tx_byte, 8'h00);
        ev_tx(1);        check(tx_byte == 8'h08, "R6 byte1", tx_byte, 8'h08);
        ev_tx(1);        check(tx_byte == 8'h00, "R6 byte2", tx_byte, 8'h00);
        ev_tx(1);        check(tx_byte == 8'h00 && tx_en, "R7 wrap to byte0", tx_byte, 8'h00);
        ev_tx(1);        check(tx_byte == 8'h08, "R7 continue after wrap", tx_byte, 8'h08);
        ev_tx(0);        check(tx_en == 0 && tx_byte == 8'hFF, "R8 nack ends", {tx_en, tx_byte}, 9'h0FF);
        ev_start();
        ev_byte(8'hF9);  check(ack_req == 0 && tx_en == 0, "R8 no rearm after nack", ack_req, 0);
        ev_stop();

        // Unarmed F9.
        ev_start();
        ev_byte(8'hF9);  check(ack_req == 0 && tx_en == 0, "R5 unarmed F9", ack_req, 0);
        ev_stop();

        // Foreign address after F8.
        ev_start();
        ev_byte(8'hF8);
        ev_byte(8'h90);  check(ack_req == 0, "R3 other address refused", ack_req, 0);
        ev_start();
        ev_byte(8'hF9);  check(ack_req == 0, "R3 sequence dropped", ack_req, 0);
        ev_stop();

        // STOP between own address and repeated START.
        ev_start(); ev_byte(8'hF8); ev_byte(8'h48);
        ev_stop();       check(ack_req == 0, "R9 stop clears ack", ack_req, 0);
        ev_start();
        ev_byte(8'hF9);  check(ack_req == 0 && tx_en == 0, "R9 stop disarms", ack_req, 0);
        ev_stop();

        // Repeated START addressed elsewhere.
        ev_start(); ev_byte(8'hF8); ev_byte(8'h48);
        ev_start();
        ev_byte(8'h91);  check(ack_req == 0, "R10 foreign restart", ack_req, 0);
        ev_start();
        ev_byte(8'hF9);  check(ack_req == 0 && tx_en == 0, "R10 disarmed", ack_req, 0);
        ev_stop();

        // STOP during readout.
        ev_start(); ev_byte(8'hF8); ev_byte(8'h48); ev_start(); ev_byte(8'hF9);
        ev_tx(1);        check(tx_byte == 8'h08, "R6 byte1 second run", tx_byte, 8'h08);
        ev_stop();       check(tx_en == 0 && tx_byte == 8'hFF && ack_req == 0, "R12 stop in readout", tx_byte, 8'hFF);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule